// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a word-wide data memory and the register file of a 32-bit datapath. On the load side, it takes the aligned word returned by memory, the two low bits of the effective address, an access size and an extension mode. It picks the addressed byte or half-word using big-endian lane order, where address offset 0 is the most significant byte. It then widens the result to a full register value, filling the upper bits with zeros or with the sign bit of the loaded item.

On the store side, the same address bits and size produce a byte-lane write enable. The source register's low byte or low half-word is copied onto every lane it could land in, so the memory only has to honour the enables. A half-word at an odd offset, a word at any nonzero offset, and the reserved size code are all reported as misaligned, and every data and enable output is forced to zero for that access. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `lsx_lane_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output (`ld_value`, `misalign`, `st_be`, `st_word`) is zero after that edge.
- R2: Outputs change only at a rising clock edge and reflect the inputs sampled at the previous rising edge; input changes between edges do not reach the outputs.
- R3: A byte load at offset k (0..3) returns word bits [31-8k:24-8k] in bits [7:0]; for word 0x12345678, offset 0 gives 0x12 and offset 1 gives 0x34.
- R4: A half-word load at offset 0 returns word bits [31:16] and at offset 2 returns bits [15:0]; for 0x12345678 these are 0x1234 and 0x5678 when zero-extended.
- R5: A word load at offset 0 returns the memory word unchanged, whatever `sext` is.
- R6: With `sext` = 0, all bits above the loaded byte or half-word are zero.
- R7: With `sext` = 1, all bits above the loaded item copy its top bit; for word 0x87654321 a byte at offset 0 gives 0xFFFFFF87, at offset 2 gives 0x00000043, a half-word at offset 0 gives 0xFFFF8765 and at offset 2 gives 0x00004321.
- R8: `acc_size` encodes 2'b00 = byte, 2'b01 = half-word, 2'b10 = word; 2'b11 is reserved and always flagged as misaligned.
- R9: A half-word at an odd offset, a word at a nonzero offset, or the reserved size sets `misalign` to 1 and forces `ld_value`, `st_be` and `st_word` to zero; all other accesses leave `misalign` at 0.
- R10: `st_be` bit i enables word bits [8i+7:8i], so offset 0 is bit 3. A byte at offset k gives 4'b1000 >> k, a half-word at offset k gives 4'b1100 >> k, and a word gives 4'b1111.
- R11: `st_word` is `st_src[7:0]` repeated four times for a byte, `st_src[15:0]` repeated twice for a half-word, and `st_src` unchanged for a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_word | input | 32 | Aligned word read from data memory |
| addr_lo | input | 2 | Low effective-address bits (byte offset in word) |
| acc_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word, 11 reserved |
| sext | input | 1 | 1 selects sign extension, 0 zero extension |
| st_src | input | 32 | Store source register value |
| ld_value | output | 32 | Extracted and extended load result |
| misalign | output | 1 | Access is misaligned or uses the reserved size |
| st_be | output | 4 | Byte-lane write enables, bit 3 = offset 0 |
| st_word | output | 32 | Store data replicated onto the lanes |

## Verification
A wrong lane index or a swapped lane order shows up in `ld_value`, `st_be` and `st_word` on the very next clock after the access, because the unit holds no state beyond its output registers. A bad extension fill is visible in the upper bits of `ld_value` in that same cycle. A broken alignment decode either zeroes a legal access or lets data through with `misalign` high, again one cycle later. Every combination of offset, size and extension mode is swept over several words whose bytes have mixed top bits. This way each lane and each fill polarity is seen at the ports.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsx_align_chk.sv
module lsx_align_chk #(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       size,
  output logic             bad
);
  import lsx_pkg::*;

  always_comb begin
    unique case (acc_size_e'(size))
      ACC_BYTE: bad = 1'b0;
      ACC_HALF: bad = ofs[0];
      ACC_WORD: bad = |ofs;
      default:  bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsx_load_extract.sv
module lsx_load_extract #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        size,
  input  logic              sext,
  input  logic              bad,
  output logic [DATA_W-1:0] val
);
  import lsx_pkg::*;

  logic [7:0]  lane [NB];
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  logic        fill_b;
  logic        fill_h;

  // lane[k] is the byte at address offset k (big-endian: k=0 is the MSB)
  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lane[k] = word[DATA_W-1-8*k -: 8];
  end

  always_comb begin
    byte_sel = lane[ofs];
    half_sel = {lane[{ofs[OFS_W-1:1], 1'b0}], lane[{ofs[OFS_W-1:1], 1'b1}]};
    fill_b   = sext & byte_sel[7];
    fill_h   = sext & half_sel[15];
    if (bad) begin
      val = '0;
    end else begin
      unique case (acc_size_e'(size))
        ACC_BYTE: val = {{(DATA_W-8){fill_b}}, byte_sel};
        ACC_HALF: val = {{(DATA_W-16){fill_h}}, half_sel};
        ACC_WORD: val = word;
        default:  val = '0;
      endcase
    end
  end
endmodule

// File: rtl/lsx_store_lanes.sv
module lsx_store_lanes #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        size,
  input  logic              bad,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] wdata
);
  import lsx_pkg::*;

  logic [NB-1:0] byte_hit;
  logic [NB-1:0] half_hit;

  // enable bit i drives bits [8i+7:8i], which hold address offset NB-1-i
  for (genvar i = 0; i < NB; i++) begin : g_be
    localparam logic [OFS_W-1:0] LANE_OFS = OFS_W'(NB - 1 - i);
    assign byte_hit[i] = (ofs == LANE_OFS);
    assign half_hit[i] = (ofs[OFS_W-1:1] == LANE_OFS[OFS_W-1:1]);
  end

  always_comb begin
    if (bad) begin
      be    = '0;
      wdata = '0;
    end else begin
      unique case (acc_size_e'(size))
        ACC_BYTE: begin be = byte_hit; wdata = {NB{src[7:0]}};      end
        ACC_HALF: begin be = half_hit; wdata = {(NB/2){src[15:0]}}; end
        ACC_WORD: begin be = '1;       wdata = src;                 end
        default:  begin be = '0;       wdata = '0;                  end
      endcase
    end
  end
endmodule

// File: rtl/lsx_lane_unit.sv
module lsx_lane_unit #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [1:0]        acc_size,
  input  logic              sext,
  input  logic [DATA_W-1:0] st_src,
  output logic [DATA_W-1:0] ld_value,
  output logic              misalign,
  output logic [NB-1:0]     st_be,
  output logic [DATA_W-1:0] st_word
);
  logic              bad_c;
  logic [DATA_W-1:0] ld_c;
  logic [NB-1:0]     be_c;
  logic [DATA_W-1:0] wd_c;
  logic              primed_q;

  lsx_align_chk #(.OFS_W(OFS_W)) u_align (
    .ofs  (addr_lo),
    .size (acc_size),
    .bad  (bad_c)
  );

  lsx_load_extract #(.DATA_W(DATA_W)) u_load (
    .word (rd_word),
    .ofs  (addr_lo),
    .size (acc_size),
    .sext (sext),
    .bad  (bad_c),
    .val  (ld_c)
  );

  lsx_store_lanes #(.DATA_W(DATA_W)) u_store (
    .src   (st_src),
    .ofs   (addr_lo),
    .size  (acc_size),
    .bad   (bad_c),
    .be    (be_c),
    .wdata (wd_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_value <= '0;
      misalign <= 1'b0;
      st_be    <= '0;
      st_word  <= '0;
      primed_q <= 1'b0;
    end else begin
      ld_value <= ld_c;
      misalign <= bad_c;
      st_be    <= be_c;
      st_word  <= wd_c;
      primed_q <= 1'b1;
    end
  end

  assert_misalign_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (ld_value == '0 && st_be == '0 && st_word == '0));

  assert_word_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(acc_size == 2'b10 && addr_lo == '0)) |-> ld_value == $past(rd_word));

  assert_byte_onehot_be_R10: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(acc_size == 2'b00)) |-> $countones(st_be) == 1);

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(acc_size == 2'b00 && !sext)) |-> ld_value[DATA_W-1:8] == '0);

  assert_sign_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(acc_size == 2'b00 && sext))
      |-> ld_value[DATA_W-1:8] == {(DATA_W-8){ld_value[7]}});

  assert_rsvd_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $past(acc_size == 2'b11)) |-> misalign);
endmodule

// File: tb/tb_lsx_lane_unit.sv
module tb_lsx_lane_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rd_word = '0;
  logic [1:0]  addr_lo = '0;
  logic [1:0]  acc_size = '0;
  logic        sext = 1'b0;
  logic [31:0] st_src = '0;
  logic [31:0] ld_value;
  logic        misalign;
  logic [3:0]  st_be;
  logic [31:0] st_word;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  lsx_lane_unit dut (
    .clk(clk), .rst(rst), .rd_word(rd_word), .addr_lo(addr_lo),
    .acc_size(acc_size), .sext(sext), .st_src(st_src),
    .ld_value(ld_value), .misalign(misalign), .st_be(st_be), .st_word(st_word)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w, input logic [31:0] s, input logic [1:0] o,
                       input logic [1:0] sz, input logic sx,
                       output logic [31:0] ld, output logic mis,
                       output logic [3:0] be, output logic [31:0] sw);
    logic [31:0] b, h;
    b = (w >> (8 * (3 - int'(o)))) & 32'hFF;
    h = (w >> (8 * (2 - int'(o)))) & 32'hFFFF;
    ld = '0; mis = 1'b0; be = '0; sw = '0;
    case (sz)
      2'd0: begin ld = (sx && b[7]) ? (b | 32'hFFFFFF00) : b;
                  be = 4'b1000 >> o; sw = {4{s[7:0]}}; end
      2'd1: begin mis = o[0]; ld = (sx && h[15]) ? (h | 32'hFFFF0000) : h;
                  be = 4'b1100 >> o; sw = {2{s[15:0]}}; end
      2'd2: begin mis = (o != 2'd0); ld = w; be = 4'hF; sw = s; end
      default: mis = 1'b1;
    endcase
    if (mis) begin ld = '0; be = '0; sw = '0; end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [31:0] words [12];
    logic [31:0] lfsr;
    logic [31:0] e_ld, e_sw, p_ld;
    logic        e_mis;
    logic [3:0]  e_be;
    string       tg;

    words[0] = 32'h12345678; words[1] = 32'h87654321;
    words[2] = 32'h80FF7F00; words[3] = 32'h7F80017E;
    lfsr = 32'hACE1_2468;
    for (int i = 4; i < 12; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      words[i] = lfsr;
    end

    // R1: outputs zero under reset even with live inputs
    rd_word = 32'hFFFFFFFF; acc_size = 2'd0; sext = 1'b1; st_src = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    check("R1 ld_value", ld_value, 32'h0);
    check("R1 misalign", {31'b0, misalign}, 32'h0);
    check("R1 st_be", {28'b0, st_be}, 32'h0);
    check("R1 st_word", st_word, 32'h0);
    rst = 1'b0;

    // Named examples (R3, R4, R7)
    rd_word = 32'h12345678; addr_lo = 2'd1; acc_size = 2'd0; sext = 1'b0;
    @(negedge clk); check("R3 byte ofs1 of 12345678", ld_value, 32'h00000034);
    addr_lo = 2'd2; acc_size = 2'd1;
    @(negedge clk); check("R4 half ofs2 of 12345678", ld_value, 32'h00005678);
    rd_word = 32'h87654321; addr_lo = 2'd0; acc_size = 2'd0; sext = 1'b1;
    @(negedge clk); check("R7 byte ofs0 of 87654321", ld_value, 32'hFFFFFF87);
    acc_size = 2'd1;
    @(negedge clk); check("R7 half ofs0 of 87654321", ld_value, 32'hFFFF8765);
    p_ld = 32'hFFFF8765;

    // Exhaustive sweep: words x offsets x sizes x extension modes
    for (int wi = 0; wi < 12; wi++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int o = 0; o < 4; o++) begin
          for (int sx = 0; sx < 2; sx++) begin
            rd_word = words[wi]; addr_lo = 2'(o); acc_size = 2'(sz); sext = sx[0];
            st_src = {words[wi][15:0], words[wi][31:16]} ^ 32'h5AC3_3CA5;
            // R2: change between edges must not reach outputs
            #1; check("R2 hold between edges", ld_value, p_ld);
            model(rd_word, st_src, addr_lo, acc_size, sext, e_ld, e_mis, e_be, e_sw);
            @(negedge clk);
            if (e_mis)       tg = "R9 ld_value";
            else if (sz == 2) tg = "R5 ld_value";
            else if (sz == 0) tg = sx ? "R3 R7 ld_value" : "R3 R6 ld_value";
            else              tg = sx ? "R4 R7 ld_value" : "R4 R6 ld_value";
            check(tg, ld_value, e_ld);
            check("R8 R9 misalign", {31'b0, misalign}, {31'b0, e_mis});
            check(e_mis ? "R9 st_be" : "R10 st_be", {28'b0, st_be}, {28'b0, e_be});
            check(e_mis ? "R9 st_word" : "R11 st_word", st_word, e_sw);
            p_ld = e_ld;
          end
        end
      end
    end

    // R1 again: reset mid-run clears loaded outputs
    rd_word = 32'hFFFFFFFF; addr_lo = 2'd0; acc_size = 2'd2; st_src = 32'hFFFFFFFF;
    @(negedge clk); check("R5 word before reset", ld_value, 32'hFFFFFFFF);
    rst = 1'b1;
    @(negedge clk);
    check("R1 ld_value mid-run", ld_value, 32'h0);
    check("R1 st_be mid-run", {28'b0, st_be}, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule